// File: doc/BRIEF.md
# Multiplexed Bit-Serial MAC Cell

This block is one processing element of a weight-stationary systolic array that runs packed sparse filter matrices. Each cell stores one signed 8-bit weight and a channel-select value. Every cycle it receives one bit from each of eight parallel activation channels. It uses the bit of the selected channel only and forwards all eight bits, registered, to the next cell up. Several sparse filter columns can therefore share one physical column, each cell tapping the channel its own weight belongs to.

Arithmetic is bit-serial and least-significant bit first. The selected 8-bit unsigned activation is multiplied serially by the magnitude of the weight. The product is negated serially in two's complement when the weight is negative. The signed result is then added serially to a 32-bit partial sum that arrives one bit per slot, and the updated sum bit leaves registered.

An 8-bit operand only occupies 8 of the 32 bit slots of the accumulation. To fill that gap, four independent word streams are interleaved round-robin, one stream per cycle, and each stream keeps its own carry and multiplier state. A start-of-word strobe travels with the data and marks slot 0 of a stream's word. Weight and select registers load in parallel, but only while no word is in flight.

Top module: `bsmac_cell`

## Requirements
- R1: `chanOut` equals `chanIn` delayed by exactly one clock, for every channel bit and at all times after reset.
- R2: `sofOut` equals `sofIn` delayed by exactly one clock.
- R3: Clock cycle n after reset release (n = 0, 1, 2, ...) belongs to stream n mod 4. A word of a stream occupies 32 consecutive slots of that stream, slot 0 being the cycle in which `sofIn` is high. Words on different streams run independently and may overlap in time.
- R4: For a word on a stream, `sumOut` carries bit k of (P + W*X) mod 2^32 one clock after slot k. P is the 32-bit partial sum whose bit k arrives on `sumIn` at slot k. X is the unsigned 8-bit value whose bit k (k < 8) is channel `sel` of `chanIn` at slot k. W is the stored signed weight.
- R5: Negative weights, including -128, yield the two's-complement subtraction of |W|*X from P, with correct 32-bit sign extension.
- R6: With a stored weight of zero, the word on `sumOut` equals P unchanged.
- R7: The stored select value s (0 to 7) takes the multiplicand from bit s of `chanIn`. Channel bits in slots 8 to 31, and all unselected channels, have no effect on the result.
- R8: In a cycle whose stream has no word in flight and `sofIn` low, `sumOut` equals `sumIn` one clock later.
- R9: `weightIn` and `selIn` are captured when `loadEn` is high, `sofIn` is low and no stream has a word in flight. Otherwise the request is ignored and the old values stay in use.
- R10: A `sofIn` on a stream restarts that stream at slot 0 with cleared carries. This holds both directly after slot 31 (back-to-back words) and in the middle of a word (abort and restart).
- R11: During and right after reset all outputs are 0, the weight is 0 and the select value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Request to load weight and select |
| weightIn | input | 8 | Signed weight to store |
| selIn | input | 3 | Channel index to store |
| chanIn | input | 8 | One serial bit per activation channel |
| sofIn | input | 1 | Start-of-word strobe for the current stream slot |
| sumIn | input | 1 | Incoming partial-sum bit |
| chanOut | output | 8 | Registered channel bits to the next cell |
| sofOut | output | 1 | Registered start-of-word strobe |
| sumOut | output | 1 | Registered updated partial-sum bit |

## Verification
A weight load request can arrive in the same cycle as a start-of-word strobe, or while another stream is part way through a word. Both collisions must leave the old weight in force. The bench raises `loadEn` with a different weight at slot 0 of a batch and again in its middle. It then rebuilds every 32-bit result from `sumOut` and compares it with the product formed from the weight loaded beforehand. A second overlap is one stream ending slot 31 in the same stretch in which the next word's strobe arrives. Back-to-back batches and a mid-word restart check that carries from the old word never leak into the new one.

// File: rtl/bsmac_pkg.sv
package bsmac_pkg;
  // Number of interleaved word streams (accumulator width / operand width).
  localparam int STREAMS = 4;
  localparam int STR_W   = $clog2(STREAMS);

  // Strobes from control to datapath, valid for the current cycle.
  typedef struct packed {
    logic [STR_W-1:0] streamIdx; // stream owning this cycle
    logic             wordStart; // slot 0 of a word
    logic             inWord;    // this stream is inside a word
    logic             feedX;     // slot still carries a multiplicand bit
    logic             loadWe;    // weight/select write accepted
  } bsmac_ctrl_t;
endpackage

// File: rtl/bsmac_ctrl.sv
module bsmac_ctrl
  import bsmac_pkg::*;
#(
  parameter int DataW = 8,
  parameter int AccW  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sofIn,
  input  logic        loadEn,
  output bsmac_ctrl_t ctrlS
);
  localparam int SLOT_W = $clog2(AccW);

  logic [STR_W-1:0]  streamCnt;
  logic [STREAMS-1:0] activeQ;
  logic [SLOT_W-1:0] slotQ [STREAMS];

  logic              curActive;
  logic [SLOT_W-1:0] curSlot;
  logic              lastSlot;
  logic              busy;

  always_comb begin
    curActive = sofIn | activeQ[streamCnt];
    curSlot   = sofIn ? '0 : slotQ[streamCnt];
    lastSlot  = (curSlot == SLOT_W'(AccW - 1));
    busy      = |activeQ;

    ctrlS.streamIdx = streamCnt;
    ctrlS.wordStart = sofIn;
    ctrlS.inWord    = curActive;
    ctrlS.feedX     = curActive & (curSlot < SLOT_W'(DataW));
    ctrlS.loadWe    = loadEn & ~busy & ~sofIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      streamCnt <= '0;
      activeQ   <= '0;
      for (int i = 0; i < STREAMS; i++) slotQ[i] <= '0;
    end else begin
      streamCnt <= streamCnt + 1'b1;
      if (curActive) begin
        activeQ[streamCnt] <= ~lastSlot;
        slotQ[streamCnt]   <= curSlot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsmac_serial_mul.sv
module bsmac_serial_mul
  import bsmac_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [STR_W-1:0] laneIdx,
  input  logic             active,
  input  logic             start,
  input  logic             xBit,
  input  logic [DataW-1:0] mag,
  output logic             pBit
);
  // Per-lane running remainder of the shift-add product.
  logic [DataW-1:0] accQ [STREAMS];
  logic [DataW-1:0] accPrev;
  logic [DataW:0]   accSum;

  always_comb begin
    accPrev = start ? '0 : accQ[laneIdx];
    accSum  = {1'b0, accPrev} + (xBit ? {1'b0, mag} : '0);
    pBit    = active & accSum[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STREAMS; i++) accQ[i] <= '0;
    end else if (active) begin
      accQ[laneIdx] <= accSum[DataW:1];
    end
  end
endmodule

// File: rtl/bsmac_serial_add.sv
module bsmac_serial_add
  import bsmac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [STR_W-1:0] laneIdx,
  input  logic             active,
  input  logic             start,
  input  logic             carryInit,
  input  logic             aBit,
  input  logic             bBit,
  output logic             sumBit
);
  logic [STREAMS-1:0] carryQ;
  logic               cin;
  logic               cout;

  always_comb begin
    if (!active)    cin = 1'b0;
    else if (start) cin = carryInit;
    else            cin = carryQ[laneIdx];
    sumBit = aBit ^ bBit ^ cin;
    cout   = (aBit & bBit) | (aBit & cin) | (bBit & cin);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       carryQ <= '0;
    else if (active) carryQ[laneIdx] <= cout;
  end
endmodule

// File: rtl/bsmac_dp.sv
module bsmac_dp
  import bsmac_pkg::*;
#(
  parameter int DataW = 8,
  parameter int NumCh = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  bsmac_ctrl_t        ctrlS,
  input  logic [DataW-1:0]   weightIn,
  input  logic [$clog2(NumCh)-1:0] selIn,
  input  logic [NumCh-1:0]   chanIn,
  input  logic               sofIn,
  input  logic               sumIn,
  output logic [NumCh-1:0]   chanOut,
  output logic               sofOut,
  output logic               sumOut
);
  localparam int SEL_W = $clog2(NumCh);

  logic [DataW-1:0] weightQ;
  logic [SEL_W-1:0] selQ;
  logic [DataW-1:0] mag;
  logic             negW;
  logic             xBit;
  logic             pBit;
  logic             negBit;
  logic             sumBit;

  always_comb begin
    negW = weightQ[DataW-1];
    mag  = negW ? (~weightQ + 1'b1) : weightQ;
    xBit = ctrlS.feedX & chanIn[selQ];
  end

  bsmac_serial_mul #(.DataW(DataW)) uMul (
    .clk     (clk),
    .rstN    (rstN),
    .laneIdx (ctrlS.streamIdx),
    .active  (ctrlS.inWord),
    .start   (ctrlS.wordStart),
    .xBit    (xBit),
    .mag     (mag),
    .pBit    (pBit)
  );

  // Conditional two's-complement negate: invert, carry 1 in at slot 0.
  bsmac_serial_add uNeg (
    .clk       (clk),
    .rstN      (rstN),
    .laneIdx   (ctrlS.streamIdx),
    .active    (ctrlS.inWord),
    .start     (ctrlS.wordStart),
    .carryInit (negW),
    .aBit      (pBit ^ (negW & ctrlS.inWord)),
    .bBit      (1'b0),
    .sumBit    (negBit)
  );

  bsmac_serial_add uAcc (
    .clk       (clk),
    .rstN      (rstN),
    .laneIdx   (ctrlS.streamIdx),
    .active    (ctrlS.inWord),
    .start     (ctrlS.wordStart),
    .carryInit (1'b0),
    .aBit      (sumIn),
    .bBit      (negBit),
    .sumBit    (sumBit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weightQ <= '0;
      selQ    <= '0;
      chanOut <= '0;
      sofOut  <= 1'b0;
      sumOut  <= 1'b0;
    end else begin
      if (ctrlS.loadWe) begin
        weightQ <= weightIn;
        selQ    <= selIn;
      end
      chanOut <= chanIn;
      sofOut  <= sofIn;
      sumOut  <= sumBit;
    end
  end
endmodule

// File: rtl/bsmac_cell.sv
module bsmac_cell
  import bsmac_pkg::*;
#(
  parameter int DataW = 8,
  parameter int AccW  = 32,
  parameter int NumCh = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadEn,
  input  logic [DataW-1:0]         weightIn,
  input  logic [$clog2(NumCh)-1:0] selIn,
  input  logic [NumCh-1:0]         chanIn,
  input  logic                     sofIn,
  input  logic                     sumIn,
  output logic [NumCh-1:0]         chanOut,
  output logic                     sofOut,
  output logic                     sumOut
);
  bsmac_ctrl_t ctrlS;

  bsmac_ctrl #(.DataW(DataW), .AccW(AccW)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .sofIn  (sofIn),
    .loadEn (loadEn),
    .ctrlS  (ctrlS)
  );

  bsmac_dp #(.DataW(DataW), .NumCh(NumCh)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlS    (ctrlS),
    .weightIn (weightIn),
    .selIn    (selIn),
    .chanIn   (chanIn),
    .sofIn    (sofIn),
    .sumIn    (sumIn),
    .chanOut  (chanOut),
    .sofOut   (sofOut),
    .sumOut   (sumOut)
  );
endmodule

// File: rtl/bsmac_cell_chk.sv
module bsmac_cell_chk
  import bsmac_pkg::*;
#(
  parameter int NumCh = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [NumCh-1:0] chanIn,
  input logic [NumCh-1:0] chanOut,
  input logic             sofIn,
  input logic             sofOut,
  input logic             sumIn,
  input logic             sumOut,
  input bsmac_ctrl_t      ctrlS
);
  logic pastValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  a_r1_chan_forward: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> chanOut == $past(chanIn));

  a_r2_sof_forward: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> sofOut == $past(sofIn));

  a_r3_round_robin: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> ctrlS.streamIdx == STR_W'($past(ctrlS.streamIdx) + 1));

  a_r8_idle_pass: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(!ctrlS.inWord)) |-> sumOut == $past(sumIn));
endmodule

bind bsmac_cell bsmac_cell_chk #(.NumCh(NumCh)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .chanIn  (chanIn),
  .chanOut (chanOut),
  .sofIn   (sofIn),
  .sofOut  (sofOut),
  .sumIn   (sumIn),
  .sumOut  (sumOut),
  .ctrlS   (ctrlS)
);

// File: tb/bsmac_cell_test.sv
`timescale 1ns/1ps
module bsmac_cell_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadEn = 1'b0;
  logic [7:0] weightIn = '0;
  logic [2:0] selIn = '0;
  logic [7:0] chanIn = '0;
  logic       sofIn = 1'b0;
  logic       sumIn = 1'b0;
  logic [7:0] chanOut;
  logic       sofOut;
  logic       sumOut;

  always #10 clk = ~clk;

  bsmac_cell uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .weightIn(weightIn),
    .selIn(selIn), .chanIn(chanIn), .sofIn(sofIn), .sumIn(sumIn),
    .chanOut(chanOut), .sofOut(sofOut), .sumOut(sumOut)
  );

  int nRun = 0;
  int nFail = 0;
  int phase = 0;
  bit done = 0;

  // Behavioural reference state
  bit     mActive [4];
  int     mSlot [4];
  longint mX [4];
  longint mPs [4];
  int     mW = 0;
  int     mSel = 0;
  logic [31:0] outAcc [4];
  logic [31:0] lastWord [4];

  // Stimulus
  logic [7:0]  xv [4][8];
  logic [31:0] ps [4];
  int curW = 0;
  int curSel = 0;

  task automatic check(input string req, input longint actual, input longint expected);
    nRun++;
    if (actual !== expected) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic step();
    int s;
    bit act;
    int k;
    bit eb;
    bit anyAct;
    logic [7:0] pc;
    bit pSof;
    longint tot;
    s = phase;
    anyAct = 0;
    act = sofIn || mActive[s];
    k = sofIn ? 0 : mSlot[s];
    if (sofIn) begin mX[s] = 0; mPs[s] = 0; end
    if (act) begin
      if (k < 8 && chanIn[mSel]) mX[s] |= (64'sd1 << k);
      if (sumIn) mPs[s] |= (64'sd1 << k);
      tot = mPs[s] + longint'(mW) * mX[s];
      eb = tot[k];
    end else begin
      eb = sumIn;
    end
    for (int i = 0; i < 4; i++) anyAct |= mActive[i];
    if (loadEn && !anyAct && !sofIn) begin
      mW = int'($signed(weightIn));
      mSel = int'(selIn);
    end
    if (act) begin
      mActive[s] = (k != 31);
      mSlot[s] = k + 1;
    end
    pc = chanIn;
    pSof = sofIn;
    @(posedge clk);
    #1;
    check(act ? "R4 sum bit" : "R8 idle pass", longint'(sumOut), longint'(eb));
    check("R1 channel forward", longint'(chanOut), longint'(pc));
    check("R2 strobe forward", longint'(sofOut), longint'(pSof));
    if (act) begin
      outAcc[s][k] = sumOut;
      if (k == 31) lastWord[s] = outAcc[s];
    end
    phase = (phase + 1) % 4;
  endtask

  task automatic randFill();
    for (int s = 0; s < 4; s++) begin
      ps[s] = $urandom;
      for (int i = 0; i < 8; i++) xv[s][i] = 8'($urandom);
    end
  endtask

  task automatic loadW(input logic [7:0] w, input logic [2:0] sel);
    loadEn = 1'b1;
    weightIn = w;
    selIn = sel;
    sofIn = 1'b0;
    chanIn = 8'($urandom);
    sumIn = 1'($urandom);
    step();
    loadEn = 1'b0;
    curW = int'($signed(w));
    curSel = int'(sel);
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      loadEn = 1'b0;
      sofIn = 1'b0;
      chanIn = 8'($urandom);
      sumIn = 1'($urandom);
      step();
    end
  endtask

  task automatic runWords(input int mask, input int ncyc, input int loadCyc,
                          input logic [7:0] lw, input logic [2:0] ls, input string req);
    int p0;
    longint expv;
    p0 = phase;
    for (int c = 0; c < ncyc; c++) begin
      int st;
      int slot;
      bit mine;
      st = (p0 + c) % 4;
      slot = c / 4;
      mine = ((mask >> st) & 1) == 1;
      sofIn = (c < 4) && mine;
      for (int i = 0; i < 8; i++)
        chanIn[i] = (mine && slot < 8) ? xv[st][i][slot] : 1'($urandom);
      sumIn = mine ? ps[st][slot] : 1'($urandom);
      loadEn = (c == loadCyc);
      weightIn = lw;
      selIn = ls;
      step();
    end
    loadEn = 1'b0;
    sofIn = 1'b0;
    if (ncyc == 128) begin
      for (int st = 0; st < 4; st++) begin
        if (((mask >> st) & 1) == 1) begin
          expv = longint'(ps[st]) + longint'(curW) * longint'(xv[st][curSel]);
          check(req, longint'(lastWord[st]), longint'(expv[31:0]));
        end
      end
    end
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      mActive[s] = 0; mSlot[s] = 0; mX[s] = 0; mPs[s] = 0;
      outAcc[s] = '0; lastWord[s] = '0;
    end
    // R11: outputs stay zero while reset is held, even with busy inputs
    chanIn = 8'hFF; sumIn = 1'b1; sofIn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset chanOut", longint'(chanOut), 0);
    check("R11 reset sofOut", longint'(sofOut), 0);
    check("R11 reset sumOut", longint'(sumOut), 0);
    chanIn = '0; sumIn = 1'b0; sofIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // R11 / R6: weight is zero after reset, sums pass unchanged
    randFill();
    runWords(15, 128, -1, 8'd0, 3'd0, "R11 reset weight zero");

    // R4: positive weight, all four streams
    loadW(8'd37, 3'd2);
    randFill();
    runWords(15, 128, -1, 8'd0, 3'd0, "R4 positive weight");

    // R7: every select value
    for (int sel = 0; sel < 8; sel++) begin
      loadW(8'(sel * 29 + 3), 3'(sel));
      randFill();
      runWords(15, 128, -1, 8'd0, 3'd0, "R7 channel select");
    end

    // R5: negative weight
    loadW(8'hA5, 3'd7);
    randFill();
    runWords(15, 128, -1, 8'd0, 3'd0, "R5 negative weight");

    // R5: most negative weight with full-scale input
    loadW(8'h80, 3'd0);
    randFill();
    for (int s = 0; s < 4; s++) xv[s][0] = 8'hFF;
    ps[0] = 32'h0; ps[1] = 32'h7FFFFFFF; ps[2] = 32'h0; ps[3] = 32'h80000000;
    runWords(15, 128, -1, 8'd0, 3'd0, "R5 weight -128");

    // R4: largest positive product, sum wraps past 2^32
    loadW(8'd127, 3'd1);
    randFill();
    for (int s = 0; s < 4; s++) begin xv[s][1] = 8'hFF; ps[s] = 32'hFFFFFFFF; end
    runWords(15, 128, -1, 8'd0, 3'd0, "R4 wrap");

    // R6: explicit zero weight
    loadW(8'd0, 3'd3);
    randFill();
    runWords(15, 128, -1, 8'd0, 3'd0, "R6 zero weight");

    // R9: load attempts mid-word and together with a strobe are ignored
    loadW(8'd55, 3'd4);
    randFill();
    runWords(15, 128, 60, 8'd99, 3'd5, "R9 load mid-word ignored");
    randFill();
    runWords(15, 128, 0, 8'd99, 3'd5, "R9 load with strobe ignored");
    loadW(8'hFD, 3'd5);
    randFill();
    runWords(15, 128, -1, 8'd0, 3'd0, "R9 idle load accepted");

    // R10: back-to-back words, then abort and restart
    randFill();
    runWords(15, 128, -1, 8'd0, 3'd0, "R10 first word");
    randFill();
    runWords(15, 128, -1, 8'd0, 3'd0, "R10 back-to-back word");
    randFill();
    runWords(15, 50, -1, 8'd0, 3'd0, "R10 aborted word");
    randFill();
    runWords(15, 128, -1, 8'd0, 3'd0, "R10 restarted word");

    // R3: subsets of streams run independently
    randFill();
    runWords(5, 128, -1, 8'd0, 3'd0, "R3 streams 0 and 2");
    randFill();
    runWords(10, 128, -1, 8'd0, 3'd0, "R3 streams 1 and 3");

    idle(20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule